// File: doc/BRIEF.md
# Two-Way Cache Tag Directory

This block holds the tags and valid bits of a two-way set-associative cache and decides, for each looked-up byte address, whether the line is present and in which way. The address is cut into a line offset (not stored), a set index (implied by the entry's position) and a tag. The tag kept per entry is deliberately narrower than the full address would need. As a result only the region below a fixed ceiling of 2^(OFF_W+IDX_W+TAG_W) bytes can be cached. Addresses at or above that ceiling are flagged as uncacheable and are never allocated.

Each stored tag carries one even-parity bit that is checked on every lookup. A tag that compares equal but fails parity is treated as a miss, its entry is dropped, and an error pulse is raised. Fills write the tag into the way chosen by a per-set round-robin bit. Reset or an invalidate-all request clears the directory one set per clock, and the block reports busy while that is in progress.

Top module: `tag_dir`

## Requirements
- R1: The lowest OFF_W address bits select a byte inside a line and have no effect on lookups or fills. The next IDX_W bits select the set, and the TAG_W bits above those are compared and stored.
- R2: A lookup address at or above 2^(OFF_W+IDX_W+TAG_W) returns uncacheable=1 and hit=0, even when its low bits alias a stored entry.
- R3: A fill whose address is at or above the ceiling changes nothing. Existing entries stay, and the set's round-robin bit keeps its value.
- R4: A fill stores the tag in the way given by the set's round-robin bit, marks it valid and then flips that bit. After a clear, every round-robin bit selects way 0.
- R5: hit is 1 when some way holds a valid entry with an equal tag and good parity. hit_way names that way, and the lower way wins when both match. On a miss, hit_way is 0.
- R6: A lookup accepted while not busy gives rsp_valid=1 on the following cycle with hit, hit_way, uncacheable and tag_error. Without a response, all four of these are 0.
- R7: If a tag compares equal but its stored parity is wrong, the lookup reports a miss with tag_error=1, and that entry becomes invalid. A repeated lookup then misses with tag_error=0.
- R8: After synchronous reset, or after invalidate_all is taken while idle, busy stays high for exactly 2^IDX_W cycles. Afterwards every entry is invalid. Lookups made while busy produce no response.
- R9: fill_corrupt together with a fill stores the inverted parity bit, so that the entry fails its next tag match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts a clearing sweep |
| invalidate_all | input | 1 | Request to clear every entry |
| lookup | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Byte address to look up |
| fill | input | 1 | Allocate fill_addr's line |
| fill_addr | input | ADDR_W | Byte address of the line to allocate |
| fill_corrupt | input | 1 | Store inverted parity with this fill (error injection) |
| busy | output | 1 | Clearing sweep in progress; lookups and fills ignored |
| rsp_valid | output | 1 | Lookup result present |
| hit | output | 1 | Line present |
| hit_way | output | 1 | Way that hit |
| uncacheable | output | 1 | Address at or above the cacheable ceiling |
| tag_error | output | 1 | Parity failure on a matching tag |

## Verification
The bench builds the directory with a 12-bit address, 4-byte lines, 8 sets and a 4-bit tag, which puts the cacheable ceiling at 512 bytes. With that shape, every line address below the ceiling and every tag of every set can be swept. Addresses above the ceiling can be chosen so that they alias real entries, and the sweep length can be counted in full. Round-robin wrap, same-tag duplicates in both ways and injected parity faults are each reached with a handful of fills.

// File: rtl/tag_dir.sv
module tag_dir #(
  parameter int ADDR_W = 30,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              invalidate_all,
  input  logic              lookup,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_corrupt,
  output logic              busy,
  output logic              rsp_valid,
  output logic              hit,
  output logic              hit_way,
  output logic              uncacheable,
  output logic              tag_error
);
  localparam int SETS = 1 << IDX_W;
  localparam int CEIL_W = OFF_W + IDX_W + TAG_W;
  localparam logic [ADDR_W:0] CEIL = (ADDR_W+1)'(1) << CEIL_W;

  logic [TAG_W:0]   ent_q [2][SETS];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  rr_q;
  logic [IDX_W-1:0] sweep_q;

  wire [IDX_W-1:0] l_idx = lk_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] l_tag = lk_addr[OFF_W+IDX_W +: TAG_W];
  wire             l_unc = {1'b0, lk_addr} >= CEIL;
  wire [IDX_W-1:0] f_idx = fill_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] f_tag = fill_addr[OFF_W+IDX_W +: TAG_W];
  wire             f_unc = {1'b0, fill_addr} >= CEIL;

  wire go  = lookup & ~busy;
  wire fgo = fill & ~busy & ~f_unc;
  wire f_way = rr_q[f_idx];

  logic [1:0] match, bad;
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign match[w] = vld_q[w][l_idx] && (ent_q[w][l_idx][TAG_W-1:0] == l_tag) && !l_unc;
    assign bad[w]   = ^ent_q[w][l_idx];
  end
  wire [1:0] good = match & ~bad;
  wire [1:0] errv = match & bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b1;
      sweep_q     <= '0;
      rsp_valid   <= 1'b0;
      hit         <= 1'b0;
      hit_way     <= 1'b0;
      uncacheable <= 1'b0;
      tag_error   <= 1'b0;
    end else begin
      rsp_valid   <= go;
      hit         <= go & (|good);
      hit_way     <= go & good[1] & ~good[0];
      uncacheable <= go & l_unc;
      tag_error   <= go & (|errv);
      if (busy) begin
        vld_q[0][sweep_q] <= 1'b0;
        vld_q[1][sweep_q] <= 1'b0;
        rr_q[sweep_q]     <= 1'b0;
        sweep_q           <= sweep_q + 1'b1;
        if (&sweep_q) busy <= 1'b0;
      end else begin
        if (invalidate_all) begin
          busy    <= 1'b1;
          sweep_q <= '0;
        end
        if (go) begin
          if (errv[0]) vld_q[0][l_idx] <= 1'b0;
          if (errv[1]) vld_q[1][l_idx] <= 1'b0;
        end
        if (fgo) begin
          ent_q[f_way][f_idx] <= {(^f_tag) ^ fill_corrupt, f_tag};
          vld_q[f_way][f_idx] <= 1'b1;
          rr_q[f_idx]         <= ~f_way;
        end
      end
    end
  end
endmodule

module tag_dir_chk (
  input logic clk,
  input logic rst,
  input logic lookup,
  input logic busy,
  input logic rsp_valid,
  input logic hit,
  input logic hit_way,
  input logic uncacheable,
  input logic tag_error
);
  p_unc_never_hits_r2: assert property (@(posedge clk) disable iff (rst)
    uncacheable |-> !hit);
  p_hit_clean_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!tag_error && !uncacheable && rsp_valid));
  p_rsp_from_lookup_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lookup && !busy));
  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!hit && !hit_way && !uncacheable && !tag_error));
  p_err_is_miss_r7: assert property (@(posedge clk) disable iff (rst)
    tag_error |-> (rsp_valid && !hit));
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !rsp_valid);
endmodule

bind tag_dir tag_dir_chk u_chk (
  .clk(clk), .rst(rst), .lookup(lookup), .busy(busy), .rsp_valid(rsp_valid),
  .hit(hit), .hit_way(hit_way), .uncacheable(uncacheable), .tag_error(tag_error)
);

// File: tb/sim_tag_dir.sv
`timescale 1ns/1ps
module sim_tag_dir;
  localparam int AW = 12, OW = 2, IW = 3, TW = 4;
  localparam int SETS = 1 << IW;
  localparam int CEIL = 1 << (OW + IW + TW);

  logic clk = 0, rst = 1, invalidate_all = 0, lookup = 0, fill = 0, fill_corrupt = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic busy, rsp_valid, hit, hit_way, uncacheable, tag_error;

  tag_dir #(.ADDR_W(AW), .OFF_W(OW), .IDX_W(IW), .TAG_W(TW)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mv [2][SETS];
  bit mp [2][SETS];
  int mt [2][SETS];
  bit mrr [SETS];

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      mv[0][s] = 0; mv[1][s] = 0; mrr[s] = 0;
    end
  endtask

  task automatic do_fill(int a, bit bad);
    int i, t;
    bit w;
    fill = 1; fill_addr = AW'(a); fill_corrupt = bad;
    @(posedge clk); @(negedge clk);
    fill = 0; fill_corrupt = 0;
    if (a < CEIL) begin
      i = (a >> OW) % SETS; t = (a >> (OW + IW)) % (1 << TW);
      w = mrr[i];
      mt[w][i] = t; mv[w][i] = 1; mp[w][i] = !bad; mrr[i] = !w;
    end
  endtask

  task automatic do_look(int a, string r);
    int i, t, eh, ew, ee;
    bit unc, m;
    unc = a >= CEIL;
    i = (a >> OW) % SETS; t = (a >> (OW + IW)) % (1 << TW);
    eh = 0; ew = 0; ee = 0;
    for (int w = 0; w < 2; w++) begin
      m = mv[w][i] && mt[w][i] == t && !unc;
      if (m && mp[w][i] && eh == 0) begin eh = 1; ew = w; end
      if (m && !mp[w][i]) begin ee = 1; mv[w][i] = 0; end
    end
    lookup = 1; lk_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    lookup = 0;
    chk({r, " rsp_valid R6"}, rsp_valid, 1);
    chk({r, " hit R5"}, hit, eh);
    chk({r, " hit_way R5"}, hit_way, ew);
    chk({r, " uncacheable R2"}, uncacheable, unc);
    chk({r, " tag_error R7"}, tag_error, ee);
  endtask

  task automatic count_busy(string r);
    int n = 0;
    while (busy && n < 100) begin
      if (n == 1) lookup = 1;
      @(posedge clk); @(negedge clk);
      if (n == 1) begin
        lookup = 0;
        chk({r, " no response while busy R8"}, rsp_valid, 0);
      end
      n++;
    end
    chk({r, " busy length R8"}, n, SETS);
    model_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset busy R8", busy, 1);
    chk("reset rsp_valid R6", rsp_valid, 0);
    rst = 0;
    count_busy("after reset");

    for (int a = 0; a < CEIL; a += 4) do_look(a + (a >> 2) % 4, "empty R8");

    for (int s = 0; s < SETS; s++) begin
      do_fill((s << 5) | (s << 2) | (s % 4), 0);
      do_fill((((s + 5) % 16) << 5) | (s << 2), 0);
    end
    for (int t = 0; t < 16; t++)
      for (int s = 0; s < SETS; s++)
        do_look((t << 5) | (s << 2) | ((t + s) % 4), "sweep R1");

    do_fill((9 << 5) | (0 << 2), 0);
    do_look((9 << 5), "rr wrap R4");
    do_look((0 << 5), "evicted R4");
    do_look((5 << 5), "kept R4");

    do_look(CEIL + ((3 << 5) | (3 << 2)), "alias above ceiling R2");
    do_look(4095, "top address R2");
    do_fill(CEIL + (12 << 5) + (3 << 2), 0);
    do_look(CEIL + (12 << 5) + (3 << 2), "ignored fill R3");
    do_look((3 << 5) | (3 << 2), "entry kept R3");
    do_look((8 << 5) | (3 << 2), "entry kept R3");
    do_fill((14 << 5) | (3 << 2), 0);
    do_look((14 << 5) | (3 << 2) | 1, "rr unchanged R3");
    do_look((3 << 5) | (3 << 2), "way0 replaced R3");

    do_fill((7 << 5) | (5 << 2), 1);
    do_look((7 << 5) | (5 << 2), "corrupt R9");
    do_look((7 << 5) | (5 << 2), "after error R7");
    do_look((10 << 5) | (5 << 2), "other way R7");

    do_fill((2 << 5) | (6 << 2), 0);
    do_fill((2 << 5) | (6 << 2) | 3, 0);
    do_look((2 << 5) | (6 << 2), "duplicate lowest way R5");

    invalidate_all = 1;
    @(posedge clk); @(negedge clk);
    invalidate_all = 0;
    count_busy("invalidate");
    for (int t = 0; t < 16; t++)
      for (int s = 0; s < SETS; s++)
        do_look((t << 5) | (s << 2), "cleared R8");
    do_fill((4 << 5) | (1 << 2), 0);
    do_fill((6 << 5) | (1 << 2), 0);
    do_look((6 << 5) | (1 << 2), "rr after clear R4");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R6: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule